// File: doc/BRIEF.md
# Multi-Slope Run-Down Sequencer

This block controls the run-down of an integrating converter. It does not use one long discharge. It applies a series of slopes, and each slope is weaker than the one before it by a constant base B. Slope 0 drives the integrator downward through the heavy reference resistor. Slope 1 drives it back upward through a resistor B times larger. Each later slope reverses direction again, so the integrator output settles closer and closer to zero. Only one slope-select line is active at a time. Each line switches one reference resistor, and a direction output picks the polarity of the reference.

The sequencer reads a comparator that reports whether the integrator output is above zero. It ends the current slope on the first clock edge at which the comparator shows that zero has been crossed. Every slope has a counter with a limit. A slope whose counter reaches its limit ends there and raises an error flag. The count of each slope is folded into a signed result using powers of B. Slopes that push charge upward enter the result with a negative sign. A one-cycle done pulse marks the end of the conversion.

Top module: `mslope_rundown`

## Requirements
- R1: While reset is held, and after it is released with no start, `slope_sel_o` is 0, `busy_o`, `dir_up_o`, `done_o` and `sat_err_o` are 0, and `result_o` is 0.
- R2: A high `start_i` sampled while `busy_o` is low starts a conversion. From the next cycle on, `busy_o` is 1 and `slope_sel_o` equals 1, which selects slope 0.
- R3: During a conversion, `slope_sel_o` has exactly one bit set, and bit k selects slope k. The slopes run in order 0, 1, ..., NUM_SLOPES-1. Slope k+1 is selected in the cycle right after slope k ends, with no idle cycle between them. A slope whose count is c is active for c+1 cycles.
- R4: `dir_up_o` is 0 during even-numbered slopes (downward, starting with slope 0) and 1 during odd-numbered slopes (upward).
- R5: An even slope ends at the first clock edge that samples `cmp_i`=0. An odd slope ends at the first clock edge that samples `cmp_i`=1. The count of the slope is the number of edges it was active before that edge, so a slope that sees the end level at its first edge has count 0.
- R6: `result_o` is the two's-complement value of the sum over k of (-1)^k * count_k * B^(NUM_SLOPES-1-k). It is valid in the cycle after the last slope ends. In that same cycle `done_o` is high, for one cycle only. `result_o` then holds until the next accepted start.
- R7: The count of slope 0 is limited to FIRST_MAX and the count of every later slope to LATER_MAX. A slope that reaches its limit without seeing its end level ends at that edge with the count equal to the limit. In that case `sat_err_o` rises and stays high until the next accepted start clears it.
- R8: If the end level arrives on the same edge at which the count reaches the limit, the slope counts as ended by the comparator: the count equals the limit and `sat_err_o` stays 0.
- R9: A high `start_i` while `busy_o` is high has no effect on the slope sequence, the conversion length or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin a conversion (accepted when idle) |
| cmp_i | input | 1 | Comparator: 1 when the integrator output is above zero |
| slope_sel_o | output | NUM_SLOPES | One-hot reference resistor select, bit k = slope k |
| dir_up_o | output | 1 | Reference polarity, 1 = drive integrator upward |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | RES_W | Signed combined run-down result |
| sat_err_o | output | 1 | A slope hit its count limit in the current or last conversion |

## Verification
Two decisions can land on the same clock edge: the comparator ending a slope, and the slope counter reaching its limit. The bench forces this case by holding the comparator away from its end level for exactly the limit number of edges of each slope and then flipping it. It then requires the slope to have exactly limit+1 active cycles, the count to equal the limit, and the error flag to stay clear. This outcome is compared against separate runs in which the crossing comes one edge too late, where the same count must appear but with the flag set.

// File: rtl/mslope_pkg.sv
package mslope_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mslope_slope_ctr.sv
// Per-slope clock counter with a slope-dependent limit.
module mslope_slope_ctr #(
  parameter int CNT_W     = 8,
  parameter int FIRST_MAX = 200,
  parameter int LATER_MAX = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             first_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_limit_o
);
  localparam logic [CNT_W-1:0] LIM_FIRST = CNT_W'(FIRST_MAX);
  localparam logic [CNT_W-1:0] LIM_LATER = CNT_W'(LATER_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             cnt_en;

  always_comb begin
    limit  = first_i ? LIM_FIRST : LIM_LATER;
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q == limit);

  // R7
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
endmodule

// File: rtl/mslope_combiner.sv
// Folds each finished slope count into the result: acc = acc*BASE +/- count.
module mslope_combiner #(
  parameter int BASE  = 10,
  parameter int CNT_W = 8,
  parameter int RES_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    load_i,
  input  logic                    neg_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic signed [RES_W-1:0] acc_o
);
  localparam logic signed [RES_W-1:0] BASE_S = RES_W'(BASE);

  logic signed [RES_W-1:0] acc_q, acc_d, scaled, term;
  logic                    acc_en;

  always_comb begin
    scaled = acc_q * BASE_S;
    term   = $signed({{(RES_W-CNT_W){1'b0}}, cnt_i});
    acc_en = clr_i | load_i;
    if (clr_i)      acc_d = '0;
    else if (neg_i) acc_d = scaled - term;
    else            acc_d = scaled + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/mslope_ctrl.sv
// Slope sequencing: start, per-slope termination, direction, error flag.
module mslope_ctrl #(
  parameter int NUM_SLOPES = 3,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             at_limit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             first_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             load_o,
  output logic             neg_o,
  output logic             done_o,
  output logic             sat_err_o
);
  import mslope_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOPES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d, done_q, done_d;
  logic             running, start_ok, end_cmp, slope_end, sat_hit, last;

  always_comb begin
    running   = (state_q == ST_RUN);
    start_ok  = (state_q == ST_IDLE) && start_i;
    // even slopes go down and end on cmp=0, odd slopes go up and end on cmp=1
    end_cmp   = running && (cmp_i == idx_q[0]);
    slope_end = running && (end_cmp || at_limit_i);
    sat_hit   = running && at_limit_i && !end_cmp;
    last      = (idx_q == LAST_IDX);

    state_d = state_q;
    idx_d   = idx_q;
    if (start_ok) begin
      state_d = ST_RUN;
      idx_d   = '0;
    end else if (slope_end) begin
      if (last) state_d = ST_IDLE;
      else      idx_d   = idx_q + IDX_W'(1);
    end

    err_d = err_q;
    if (start_ok)     err_d = 1'b0;
    else if (sat_hit) err_d = 1'b1;

    done_d = slope_end && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign idx_o     = idx_q;
  assign busy_o    = running;
  assign first_o   = (idx_q == '0);
  assign cnt_clr_o = start_ok || slope_end;
  assign cnt_inc_o = running && !slope_end;
  assign load_o    = slope_end;
  assign neg_o     = idx_q[0];
  assign done_o    = done_q;
  assign sat_err_o = err_q;

  // R3
  slope_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slope_end && !last) |=> (state_q == ST_RUN && idx_q == $past(idx_q) + IDX_W'(1)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mslope_rundown.sv
// Multi-slope run-down sequencer top level.
module mslope_rundown #(
  parameter int BASE       = 10,  // 2 .. 16
  parameter int NUM_SLOPES = 3,   // >= 2
  parameter int FIRST_MAX  = 200,
  parameter int LATER_MAX  = 20,
  localparam int MAX_LIM   = (FIRST_MAX > LATER_MAX) ? FIRST_MAX : LATER_MAX,
  localparam int CNT_W     = $clog2(MAX_LIM + 1),
  localparam int RES_W     = CNT_W + (NUM_SLOPES - 1) * $clog2(BASE) + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  cmp_i,
  output logic [NUM_SLOPES-1:0] slope_sel_o,
  output logic                  dir_up_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [RES_W-1:0]      result_o,
  output logic                  sat_err_o
);
  localparam int IDX_W = (NUM_SLOPES > 1) ? $clog2(NUM_SLOPES) : 1;

  logic             rst_meta, rst_sync;
  logic [IDX_W-1:0] idx;
  logic             busy, first, cnt_clr, cnt_inc, load, neg, at_limit;
  logic [CNT_W-1:0] cnt;
  logic signed [RES_W-1:0] acc;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  mslope_ctrl #(.NUM_SLOPES(NUM_SLOPES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_sync), .start_i(start_i), .cmp_i(cmp_i),
    .at_limit_i(at_limit), .idx_o(idx), .busy_o(busy), .first_o(first),
    .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc), .load_o(load), .neg_o(neg),
    .done_o(done_o), .sat_err_o(sat_err_o)
  );

  mslope_slope_ctr #(.CNT_W(CNT_W), .FIRST_MAX(FIRST_MAX), .LATER_MAX(LATER_MAX)) ctr_i (
    .clk(clk), .rst_n(rst_sync), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .first_i(first), .cnt_o(cnt), .at_limit_o(at_limit)
  );

  mslope_combiner #(.BASE(BASE), .CNT_W(CNT_W), .RES_W(RES_W)) comb_i (
    .clk(clk), .rst_n(rst_sync), .clr_i(cnt_clr && !busy), .load_i(load),
    .neg_i(neg), .cnt_i(cnt), .acc_o(acc)
  );

  for (genvar gi = 0; gi < NUM_SLOPES; gi++) begin : g_sel
    assign slope_sel_o[gi] = busy && (idx == IDX_W'(gi));
  end

  assign dir_up_o = busy && idx[0];
  assign busy_o   = busy;
  assign result_o = acc;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!busy_o && start_i) |=> (busy_o && slope_sel_o[0]));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    busy_o ? ($countones(slope_sel_o) == 1) : (slope_sel_o == '0));
endmodule

// File: tb/mslope_rundown_tb.sv
`timescale 1ns/1ps
module mslope_rundown_tb_top;
  localparam int B  = 10;
  localparam int NS = 3;
  localparam int FM = 200;
  localparam int LM = 20;
  localparam int RW = 18;

  logic          clk = 1'b0;
  logic          rst_n, start_i, cmp_i;
  logic [NS-1:0] slope_sel_o;
  logic          dir_up_o, busy_o, done_o, sat_err_o;
  logic [RW-1:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mslope_rundown #(.BASE(B), .NUM_SLOPES(NS), .FIRST_MAX(FM), .LATER_MAX(LM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .slope_sel_o(slope_sel_o), .dir_up_o(dir_up_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .sat_err_o(sat_err_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint res_val();
    return longint'($signed(result_o));
  endfunction

  // Runs one conversion whose slopes would see their end level after req[k]
  // active edges; poke_at>0 raises start_i at that busy cycle.
  task automatic convert(input int req[NS], input int poke_at, input string req_tag);
    int     eff[NS];
    int     dur, k, n, cyc;
    bit     err_exp;
    longint exp_res;
    err_exp = 0;
    exp_res = 0;
    for (int i = 0; i < NS; i++) begin
      int lim;
      lim = (i == 0) ? FM : LM;
      eff[i] = (req[i] > lim) ? lim : req[i];
      if (req[i] > lim) err_exp = 1;
      exp_res = exp_res * B + ((i % 2 == 1) ? -eff[i] : eff[i]);
    end
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R2", "busy after start", busy_o, 1);
    k = 0; n = 0; cyc = 0;
    while (k < NS) begin
      dur = eff[k] + 1;
      // R3 / R4: slope order, one-hot select and direction
      chk("R3", $sformatf("slope_sel in slope %0d", k), slope_sel_o, (1 << k));
      if (n == 0) chk("R4", $sformatf("dir in slope %0d", k), dir_up_o, k % 2);
      cmp_i = (n == req[k]) ? k[0] : ~k[0];
      start_i = (poke_at > 0 && cyc == poke_at);
      n++; cyc++;
      if (n == dur) begin k++; n = 0; end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R6", "done at end", done_o, 1);
    chk("R3", "busy low at end", busy_o, 0);
    chk("R6", {req_tag, " result"}, res_val(), exp_res);
    chk("R7", {req_tag, " sat_err"}, sat_err_o, err_exp);
    @(negedge clk);
    chk("R6", "done is one cycle", done_o, 0);
    repeat (3) @(negedge clk);
    chk("R6", "result held while idle", res_val(), exp_res);
    chk("R7", "sat_err held while idle", sat_err_o, err_exp);
  endtask

  task automatic t_reset();
    chk("R1", "slope_sel", slope_sel_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "dir", dir_up_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "sat_err", sat_err_o, 0);
    chk("R1", "result", res_val(), 0);
  endtask

  task automatic t_basic();
    convert('{57, 3, 8}, 0, "R6 basic");
    convert('{5, 12, 0}, 0, "R6 mixed");
    convert('{0, 15, 3}, 0, "R6 negative");
  endtask

  task automatic t_zero_counts();
    // R5: end level already present at each slope's first edge
    convert('{0, 0, 0}, 0, "R5 zero");
    convert('{1, 1, 1}, 0, "R5 one");
  endtask

  task automatic t_saturation();
    convert('{250, 4, 2}, 0, "R7 first-sat");
    convert('{10, 30, 1}, 0, "R7 later-sat");
    convert('{3, 2, 1}, 0, "R7 clears");
  endtask

  task automatic t_exact_limit();
    convert('{200, 20, 20}, 0, "R8 exact");
    convert('{201, 20, 21}, 0, "R8 one-late");
  endtask

  task automatic t_start_busy();
    convert('{40, 7, 9}, 4, "R9 busy-start");
    convert('{2, 19, 11}, 25, "R9 busy-start late");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; cmp_i = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_zero_counts();
    t_saturation();
    t_exact_limit();
    t_start_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule